// File: doc/BRIEF.md
# Rename Error Response Controller

This controller decides how the core recovers when a parity check in the register renaming logic fails. It watches two error flags. One comes from the check on physical identifiers read from the alias table when sources are renamed. The other comes from the check on identifiers taken from the free list when destinations are renamed.

A lookup error is handled by a one-cycle flush request back to the oldest in-flight instruction. The snapshot and history state can then rebuild the alias table. An allocation error cannot be repaired that way, because a corrupted identifier in the free list has no clean copy anywhere. For that case the controller raises a sleep-style initialisation request and holds it until the refill reports completion. While it waits, renaming is stalled and further errors are ignored. The refill puts fresh identifiers with freshly generated parity into the free list.

Lookup errors that repeat with no retirement in between are counted. When the count reaches a configurable limit, the controller stops retrying. It then latches an uncorrectable-error output.

Top module: `rename_err_ctrl`

## Requirements
- R1: After reset, `flushReq`, `initReq`, `renameStall` and `uncorrectable` are all low.
- R2: A lookup error (`srcErr` high) sampled while running normally drives `flushReq` high in the following cycle only, for exactly one cycle.
- R3: An allocation error (`allocErr` high with `srcErr` low) sampled while running normally raises `initReq` and `renameStall` from the next cycle. No flush is produced for it.
- R4: `initReq` and `renameStall` stay high until `initDone` is sampled and fall in the cycle after. An `initDone` sampled while running normally has no effect on any output.
- R5: While an initialisation is pending, `srcErr` and `allocErr` are ignored: no flush is produced and `initReq` stays high.
- R6: Lookup errors are counted from the last retirement. The error that brings the count to `ABORT_LIMIT` produces no flush. Instead it raises `uncorrectable` from the next cycle. Every earlier error produces a flush.
- R7: A sampled `retireValid` clears the count. If a lookup error is sampled in the same cycle as a retirement, that error counts as the first one.
- R8: When `srcErr` and `allocErr` are sampled together while running normally, only the flush is produced, and `initReq` stays low.
- R9: `uncorrectable` stays high until reset. `renameStall` is high with it, and all later error, retire and done inputs produce neither flush nor initialisation.
- R10: Starting an initialisation clears the lookup-error count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcErr | input | 1 | Parity failure on an identifier read from the alias table |
| allocErr | input | 1 | Parity failure on an identifier taken from the free list |
| retireValid | input | 1 | At least one instruction retired this cycle |
| initDone | input | 1 | The rename-state initialisation has finished |
| flushReq | output | 1 | One-cycle request to flush back to the oldest instruction |
| initReq | output | 1 | Sleep interrupt requesting rename-state initialisation, held until done |
| renameStall | output | 1 | Blocks new renames during initialisation or after abort |
| uncorrectable | output | 1 | Sticky: flush recovery was abandoned |

## Verification
The bench builds the controller with `ABORT_LIMIT` set to 4. With that value, three flushes followed by an abort take only a handful of cycles, so the whole retry ladder can be walked several times. That covers a plain run of errors, a ladder broken by a retirement, a retirement in the same cycle as an error, and a ladder restarted by an initialisation. The small limit also makes it cheap to show that an initialisation empties the count: three further errors after the refill must all still flush.

// File: rtl/rerc_pkg.sv
package rerc_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_INIT = 2'd1,
    ST_DEAD = 2'd2
  } rercState_e;

  typedef struct packed {
    logic flush;     // issue one flush attempt
    logic countErr;  // bump the attempt counter
    logic clearCnt;  // empty the attempt counter
  } rercStrobe_t;

endpackage

// File: rtl/rerc_dp.sv
module rerc_dp #(
  parameter int ABORT_LIMIT = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  retireValid,
  input  rerc_pkg::rercStrobe_t strobe,
  output logic                  reachLimit,
  output logic                  flushReq
);
  localparam int CNT_W = $clog2(ABORT_LIMIT + 1);

  logic [CNT_W-1:0] attemptCnt;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] nextCnt;

  // retirement in the same cycle restarts the ladder before counting
  assign baseCnt    = retireValid ? '0 : attemptCnt;
  assign nextCnt    = baseCnt + CNT_W'(1);
  assign reachLimit = (nextCnt >= CNT_W'(ABORT_LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attemptCnt <= '0;
      flushReq   <= 1'b0;
    end else begin
      flushReq <= strobe.flush;
      if (strobe.clearCnt) begin
        attemptCnt <= '0;
      end else if (strobe.countErr) begin
        attemptCnt <= nextCnt;
      end else if (retireValid) begin
        attemptCnt <= '0;
      end
    end
  end

  // R2
  flush_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !flushReq);

  // R6
  cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    attemptCnt < CNT_W'(ABORT_LIMIT));

endmodule

// File: rtl/rerc_ctrl.sv
module rerc_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  srcErr,
  input  logic                  allocErr,
  input  logic                  initDone,
  input  logic                  reachLimit,
  output rerc_pkg::rercStrobe_t strobe,
  output logic                  initReq,
  output logic                  uncorrectable
);
  import rerc_pkg::*;

  rercState_e state;
  rercState_e nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (srcErr) begin
          if (reachLimit) begin
            nextState = ST_DEAD;
          end else begin
            strobe.flush    = 1'b1;
            strobe.countErr = 1'b1;
          end
        end else if (allocErr) begin
          nextState       = ST_INIT;
          strobe.clearCnt = 1'b1;
        end
      end
      ST_INIT: begin
        if (initDone) nextState = ST_RUN;
      end
      ST_DEAD: nextState = ST_DEAD;
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign initReq       = (state == ST_INIT);
  assign uncorrectable = (state == ST_DEAD);

  // R9
  uncorr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    uncorrectable |=> uncorrectable);

  // R3
  init_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initReq) |-> $past(allocErr && !srcErr));

  // R4
  init_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initReq && !initDone) |=> initReq);

endmodule

// File: rtl/rename_err_ctrl.sv
module rename_err_ctrl #(
  parameter int ABORT_LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic srcErr,
  input  logic allocErr,
  input  logic retireValid,
  input  logic initDone,
  output logic flushReq,
  output logic initReq,
  output logic renameStall,
  output logic uncorrectable
);
  rerc_pkg::rercStrobe_t strobe;
  logic                  reachLimit;

  rerc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .srcErr       (srcErr),
    .allocErr     (allocErr),
    .initDone     (initDone),
    .reachLimit   (reachLimit),
    .strobe       (strobe),
    .initReq      (initReq),
    .uncorrectable(uncorrectable)
  );

  rerc_dp #(.ABORT_LIMIT(ABORT_LIMIT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .retireValid(retireValid),
    .strobe     (strobe),
    .reachLimit (reachLimit),
    .flushReq   (flushReq)
  );

  assign renameStall = initReq | uncorrectable;

  // R8
  flush_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flushReq && (initReq || uncorrectable)));

endmodule

// File: tb/rename_err_ctrl_bench.sv
module rename_err_ctrl_bench;
  localparam int LIMIT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcErr = 1'b0, allocErr = 1'b0, retireValid = 1'b0, initDone = 1'b0;
  logic flushReq, initReq, renameStall, uncorrectable;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rename_err_ctrl #(.ABORT_LIMIT(LIMIT)) u_rename_err_ctrl (
    .clk(clk), .rstN(rstN), .srcErr(srcErr), .allocErr(allocErr),
    .retireValid(retireValid), .initDone(initDone), .flushReq(flushReq),
    .initReq(initReq), .renameStall(renameStall), .uncorrectable(uncorrectable)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs, let one edge sample them, then release
  task automatic cyc(input logic s, input logic a, input logic r, input logic d);
    srcErr = s; allocErr = a; retireValid = r; initDone = d;
    @(negedge clk);
    srcErr = 0; allocErr = 0; retireValid = 0; initDone = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R1", "flushReq", flushReq, 0);
    chk("R1", "initReq", initReq, 0);
    chk("R1", "renameStall", renameStall, 0);
    chk("R1", "uncorrectable", uncorrectable, 0);
  endtask

  task automatic testFlush();
    doReset();
    cyc(1, 0, 0, 0);
    chk("R2", "flush after error", flushReq, 1);
    chk("R2", "no init on lookup error", initReq, 0);
    cyc(0, 0, 0, 0);
    chk("R2", "flush one cycle", flushReq, 0);
  endtask

  task automatic testLimit();
    doReset();
    for (int i = 1; i < LIMIT; i++) begin
      cyc(1, 0, 0, 0);
      chk("R6", "flush before limit", flushReq, 1);
      cyc(0, 0, 0, 0);
    end
    cyc(1, 0, 0, 0);
    chk("R6", "no flush at limit", flushReq, 0);
    chk("R6", "uncorrectable at limit", uncorrectable, 1);
    chk("R9", "stall when dead", renameStall, 1);
    cyc(1, 1, 1, 1);
    chk("R9", "still dead", uncorrectable, 1);
    chk("R9", "no flush when dead", flushReq, 0);
    cyc(0, 1, 0, 0);
    chk("R9", "no init when dead", initReq, 0);
    chk("R9", "sticky", uncorrectable, 1);
  endtask

  task automatic testRetire();
    doReset();
    for (int i = 1; i < LIMIT; i++) begin cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); end
    cyc(0, 0, 1, 0);
    for (int i = 1; i < LIMIT; i++) begin
      cyc(1, 0, 0, 0);
      chk("R7", "flush after retire clear", flushReq, 1);
      cyc(0, 0, 0, 0);
    end
    chk("R7", "no abort after retire", uncorrectable, 0);
    cyc(1, 0, 1, 0);
    chk("R7", "same-cycle retire error flushes", flushReq, 1);
    cyc(0, 0, 0, 0);
    for (int i = 2; i < LIMIT; i++) begin cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); end
    chk("R7", "count at limit-1 not aborted", uncorrectable, 0);
    cyc(1, 0, 0, 0);
    chk("R7", "same-cycle error counted as first", uncorrectable, 1);
  endtask

  task automatic testInit();
    doReset();
    cyc(0, 0, 0, 1);
    chk("R4", "initDone ignored when running", initReq, 0);
    chk("R4", "no stall from stray done", renameStall, 0);
    cyc(0, 1, 0, 0);
    chk("R3", "initReq raised", initReq, 1);
    chk("R3", "stall raised", renameStall, 1);
    chk("R3", "no flush for alloc error", flushReq, 0);
    cyc(1, 0, 0, 0);
    chk("R5", "lookup error ignored in init", flushReq, 0);
    cyc(1, 1, 0, 0);
    chk("R5", "initReq held", initReq, 1);
    chk("R5", "no flush in init", flushReq, 0);
    cyc(0, 0, 0, 0);
    chk("R4", "held before done", initReq, 1);
    cyc(0, 0, 0, 1);
    chk("R4", "initReq dropped", initReq, 0);
    chk("R4", "stall dropped", renameStall, 0);
  endtask

  task automatic testInitClears();
    doReset();
    for (int i = 1; i < LIMIT; i++) begin cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); end
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1);
    for (int i = 1; i < LIMIT; i++) begin
      cyc(1, 0, 0, 0);
      chk("R10", "flush after init cleared count", flushReq, 1);
      cyc(0, 0, 0, 0);
    end
    chk("R10", "no abort after init", uncorrectable, 0);
  endtask

  task automatic testBoth();
    doReset();
    cyc(1, 1, 0, 0);
    chk("R8", "flush wins", flushReq, 1);
    chk("R8", "no init", initReq, 0);
    cyc(0, 0, 0, 0);
    chk("R8", "alloc error dropped", initReq, 0);
  endtask

  initial begin
    testReset();
    testFlush();
    testLimit();
    testRetire();
    testInit();
    testInitClears();
    testBoth();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule